// File: doc/BRIEF.md
# Oversampled UART Baud Register and Tick Generator

This block holds the 32-bit baud configuration word of a UART and turns it into the timing pulses that a transmitter and receiver need. The word carries a baud divisor, an oversampling ratio code, an edge-sampling request, a 10-bit character select and a stop-bit-count select. A prescaler divides the functional clock by the divisor to form an oversample tick. A second counter groups the ticks into bit periods. It raises a bit strobe at the end of each bit and a sample strobe near the middle of each bit. When both-edge sampling is active it adds a second sample strobe half a tick period later.

Software writes the word through a plain single-cycle write port. The stored word can be read back at all times on a combinational read bus. The block has no data stream, so no valid/ready handshake is used. The write strobe is a control pin: it is accepted on every clock edge where it is high and never stalls. Each write restarts both counters, so the new rate begins from a clean phase. The mode bits are driven straight to the serial datapath, which is outside this block.

Top module: `osr_baud_unit`

## Requirements
- R1: After reset the read bus shows 0x0F00_0000 (ratio code 15, divisor 0, all flags clear), and every strobe and mode output is low.
- R2: Bits 28:24 hold the ratio code. For codes 3 to 31 the effective oversampling ratio is the code plus one, which gives 4 to 32.
- R3: Bits 12:0 hold the divisor D. With D nonzero, `os_tick` is high for one cycle in every D cycles. The first pulse comes D-1 cycles after the clock edge that accepted the write, where the cycle right after that edge is numbered 0.
- R4: The `both_edge` output is high when bit 17 is set, and also whenever the effective ratio is 4 to 7, whatever bit 17 holds.
- R5: With effective ratio R, `bit_strobe` coincides with every R-th `os_tick`, counted from the last write.
- R6: `sample_strobe` coincides with oversample tick number floor(R/2) of every bit period.
- R7: When `both_edge` is high and D is 2 or more, `sample_strobe` also pulses floor(D/2) cycles after that mid-bit tick. When D is 1 this extra pulse does not occur.
- R8: With a divisor of 0, `os_tick`, `bit_strobe` and `sample_strobe` stay low.
- R9: Ratio codes 0, 1 and 2 are stored and read back as written, but they act as a ratio of 16.
- R10: Bit 29 drives `char10_mode` and bit 13 drives `two_stop`. Each is high when its bit is 1.
- R11: Only bits 29:24, 17 and 13:0 are stored. Every other bit reads as zero whatever was written, so writing all ones reads back as 0x3F02_3FFF.
- R12: Every write clears the prescaler and the tick counter. Strobe timing after a write therefore does not depend on the phase the counters had before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Functional clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr_en | input | 1 | Write strobe for the configuration word |
| cfg_wr_data | input | 32 | Data written to the configuration word |
| cfg_rd_data | output | 32 | Current configuration word; unused bits read as zero |
| os_tick | output | 1 | One-cycle oversample tick |
| bit_strobe | output | 1 | One-cycle pulse at the end of each bit period |
| sample_strobe | output | 1 | One-cycle mid-bit sample pulse (two per bit in both-edge mode) |
| both_edge | output | 1 | Both-edge sampling is active |
| char10_mode | output | 1 | 10-bit character mode selected |
| two_stop | output | 1 | Two stop bits selected |

## Verification
The assertions check on every cycle that the structural rules hold. The prescaler and tick counters stay below their limits. A bit strobe only occurs on an oversample tick. No strobe leaves the block while the divisor is zero. Low ratios always report both-edge sampling. The cycle right after a write carries no bit or sample strobe. Only the bench scenarios can show the exact cycle positions: the tick period, the bit period, the mid-bit sample and its half-period echo. They also cover the fallback to 16 for illegal codes, the read-back mask, and the phase restart when the same value is written again part-way through a bit.

// File: rtl/osr_baud_pkg.sv
package osr_baud_pkg;

  // Field positions inside the configuration word
  localparam int DIV_LSB     = 0;
  localparam int STOP_BIT    = 13;
  localparam int EDGE_BIT    = 17;
  localparam int RATIO_LSB   = 24;
  localparam int CHAR10_BIT  = 29;

  // Field widths as laid out in the word
  localparam int DIV_FIELD_W   = 13;
  localparam int CODE_FIELD_W  = 5;

  // Ratio handling
  localparam int MIN_LEGAL_CODE  = 3;
  localparam int FALLBACK_RATIO  = 16;
  localparam int EDGE_LIMIT      = 8;   // ratios below this force both-edge

  typedef struct packed {
    logic char10;
    logic two_stop;
    logic edge_req;
  } mode_flags_t;

  function automatic logic [31:0] stored_mask(input int div_w, input int code_w);
    logic [31:0] m;
    m = '0;
    for (int i = 0; i < div_w; i++) m[DIV_LSB + i] = 1'b1;
    for (int i = 0; i < code_w; i++) m[RATIO_LSB + i] = 1'b1;
    m[STOP_BIT]   = 1'b1;
    m[EDGE_BIT]   = 1'b1;
    m[CHAR10_BIT] = 1'b1;
    return m;
  endfunction

endpackage

// File: rtl/osr_cfg_reg.sv
module osr_cfg_reg
  import osr_baud_pkg::*;
#(
  parameter int DIV_W    = DIV_FIELD_W,
  parameter int CODE_W   = CODE_FIELD_W,
  parameter int RATIO_W  = CODE_W + 1,
  parameter int RST_CODE = 15
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [31:0]        wr_data,
  output logic [31:0]        rd_data,
  output logic [DIV_W-1:0]   divisor,
  output logic [RATIO_W-1:0] ratio,
  output logic               both_edge,
  output mode_flags_t        flags
);

  localparam logic [CODE_W-1:0]  MIN_CODE  = CODE_W'(MIN_LEGAL_CODE);
  localparam logic [RATIO_W-1:0] FB_RATIO  = RATIO_W'(FALLBACK_RATIO);
  localparam logic [RATIO_W-1:0] EDGE_LIM  = RATIO_W'(EDGE_LIMIT);

  logic [CODE_W-1:0] code_q;
  logic [DIV_W-1:0]  div_q;
  mode_flags_t       flags_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q  <= CODE_W'(RST_CODE);
      div_q   <= '0;
      flags_q <= '0;
    end else if (wr_en) begin
      code_q           <= wr_data[RATIO_LSB +: CODE_W];
      div_q            <= wr_data[DIV_LSB +: DIV_W];
      flags_q.char10   <= wr_data[CHAR10_BIT];
      flags_q.two_stop <= wr_data[STOP_BIT];
      flags_q.edge_req <= wr_data[EDGE_BIT];
    end
  end

  always_comb begin
    rd_data                       = '0;
    rd_data[RATIO_LSB +: CODE_W]  = code_q;
    rd_data[DIV_LSB +: DIV_W]     = div_q;
    rd_data[CHAR10_BIT]           = flags_q.char10;
    rd_data[STOP_BIT]             = flags_q.two_stop;
    rd_data[EDGE_BIT]             = flags_q.edge_req;
  end

  always_comb begin
    if (code_q < MIN_CODE) ratio = FB_RATIO;
    else                   ratio = RATIO_W'(code_q) + RATIO_W'(1);
  end

  assign divisor   = div_q;
  assign flags     = flags_q;
  assign both_edge = flags_q.edge_req | (ratio < EDGE_LIM);

  AST_RATIO_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (ratio >= RATIO_W'(4)) && (ratio <= RATIO_W'(32))); // R2

  AST_LOW_RATIO_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    (ratio < EDGE_LIM) |-> both_edge); // R4

endmodule

// File: rtl/osr_prescaler.sv
module osr_prescaler #(
  parameter int DIV_W = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic [DIV_W-1:0] divisor,
  output logic             os_tick,
  output logic             half_tick
);

  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] last;
  logic [DIV_W-1:0] half;
  logic             running;

  assign running = (divisor != '0);
  assign last    = divisor - DIV_W'(1);
  assign half    = (divisor >> 1) - DIV_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      cnt_q <= '0;
    else if (restart || !running)    cnt_q <= '0;
    else if (cnt_q >= last)          cnt_q <= '0;
    else                             cnt_q <= cnt_q + DIV_W'(1);
  end

  assign os_tick   = running && (cnt_q == last);
  assign half_tick = (divisor >= DIV_W'(2)) && (cnt_q == half);

  AST_DIV_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    running |-> (cnt_q < divisor)); // R3

endmodule

// File: rtl/osr_bit_timer.sv
module osr_bit_timer #(
  parameter int RATIO_W = 6,
  parameter bit EDGE_EN = 1'b1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               restart,
  input  logic               os_tick,
  input  logic               half_tick,
  input  logic [RATIO_W-1:0] ratio,
  input  logic               both_edge,
  output logic               bit_strobe,
  output logic               sample_strobe
);

  logic [RATIO_W-1:0] os_cnt_q;
  logic [RATIO_W-1:0] mid;
  logic               end_of_bit;
  logic               first_sample;
  logic               second_sample;

  assign mid        = ratio >> 1;
  assign end_of_bit = (os_cnt_q == ratio - RATIO_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        os_cnt_q <= '0;
    else if (restart)  os_cnt_q <= '0;
    else if (os_tick)  os_cnt_q <= end_of_bit ? '0 : os_cnt_q + RATIO_W'(1);
  end

  assign first_sample = os_tick && (os_cnt_q == mid - RATIO_W'(1));

  generate
    if (EDGE_EN) begin : g_edge
      assign second_sample = both_edge && half_tick && (os_cnt_q == mid);
    end else begin : g_no_edge
      assign second_sample = 1'b0;
    end
  endgenerate

  assign bit_strobe    = os_tick && end_of_bit;
  assign sample_strobe = first_sample || second_sample;

  AST_OS_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    os_cnt_q < ratio); // R5

endmodule

// File: rtl/osr_baud_unit.sv
module osr_baud_unit
  import osr_baud_pkg::*;
#(
  parameter int DIV_W    = DIV_FIELD_W,
  parameter int CODE_W   = CODE_FIELD_W,
  parameter int RST_CODE = 15
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_wr_en,
  input  logic [31:0] cfg_wr_data,
  output logic [31:0] cfg_rd_data,
  output logic        os_tick,
  output logic        bit_strobe,
  output logic        sample_strobe,
  output logic        both_edge,
  output logic        char10_mode,
  output logic        two_stop
);

  localparam int          RATIO_W = CODE_W + 1;
  localparam logic [31:0] MASK    = stored_mask(DIV_W, CODE_W);

  logic [DIV_W-1:0]   divisor;
  logic [RATIO_W-1:0] ratio;
  logic               half_tick;
  mode_flags_t        flags;

  osr_cfg_reg #(
    .DIV_W(DIV_W), .CODE_W(CODE_W), .RATIO_W(RATIO_W), .RST_CODE(RST_CODE)
  ) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_en(cfg_wr_en), .wr_data(cfg_wr_data),
    .rd_data(cfg_rd_data), .divisor(divisor), .ratio(ratio),
    .both_edge(both_edge), .flags(flags)
  );

  osr_prescaler #(.DIV_W(DIV_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .restart(cfg_wr_en), .divisor(divisor),
    .os_tick(os_tick), .half_tick(half_tick)
  );

  osr_bit_timer #(.RATIO_W(RATIO_W), .EDGE_EN(1'b1)) u_bit (
    .clk(clk), .rst_n(rst_n), .restart(cfg_wr_en), .os_tick(os_tick),
    .half_tick(half_tick), .ratio(ratio), .both_edge(both_edge),
    .bit_strobe(bit_strobe), .sample_strobe(sample_strobe)
  );

  assign char10_mode = flags.char10;
  assign two_stop    = flags.two_stop;

  AST_IDLE_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    (divisor == '0) |-> (!os_tick && !bit_strobe && !sample_strobe)); // R8

  AST_BIT_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    bit_strobe |-> os_tick); // R5

  AST_WR_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr_en |=> (!bit_strobe && !sample_strobe)); // R12

  AST_UNUSED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rd_data & ~MASK) == 32'h0); // R11

endmodule

// File: tb/osr_baud_unit_bench.sv
module osr_baud_unit_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr_en = 1'b0;
  logic [31:0] cfg_wr_data = '0;
  logic [31:0] cfg_rd_data;
  logic        os_tick, bit_strobe, sample_strobe, both_edge, char10_mode, two_stop;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #5 clk = ~clk;

  osr_baud_unit u_osr_baud_unit (
    .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_wr_data(cfg_wr_data),
    .cfg_rd_data(cfg_rd_data), .os_tick(os_tick), .bit_strobe(bit_strobe),
    .sample_strobe(sample_strobe), .both_edge(both_edge),
    .char10_mode(char10_mode), .two_stop(two_stop)
  );

  task automatic check(input string req, input string what,
                       input longint act, input longint exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  // Write in one cycle; returns at the falling edge of cycle 0 after the write edge
  task automatic do_write(input logic [31:0] v);
    @(negedge clk);
    cfg_wr_en   = 1'b1;
    cfg_wr_data = v;
    @(posedge clk);
    @(negedge clk);
    cfg_wr_en   = 1'b0;
    cfg_wr_data = '0;
  endtask

  // Compare strobes for ncyc cycles against the timing rules
  task automatic watch(input int code, input int dv, input bit edge_bit,
                       input int ncyc, input string req);
    int  r;
    bit  be;
    int  bad_t, bad_b, bad_s, at_t, at_b, at_s;
    bit  e_t, e_b, e_s, s2;
    int  k, sh;
    r  = (code < 3) ? 16 : code + 1;
    be = edge_bit || (r < 8);
    bad_t = 0; bad_b = 0; bad_s = 0; at_t = -1; at_b = -1; at_s = -1;
    check(req, "both_edge level", longint'(both_edge), longint'(be));
    for (int c = 0; c < ncyc; c++) begin
      e_t = (dv > 0) && (((c + 1) % dv) == 0);
      k   = (dv > 0) ? (c + 1) / dv : 0;
      e_b = e_t && ((k % r) == 0);
      e_s = e_t && ((k % r) == (r / 2));
      s2  = 1'b0;
      if (be && dv >= 2) begin
        sh = c + 1 - dv / 2;
        s2 = (sh > 0) && ((sh % dv) == 0) && (((sh / dv) % r) == (r / 2));
      end
      e_s = e_s || s2;
      if (os_tick != e_t)       begin bad_t++; if (at_t < 0) at_t = c; end
      if (bit_strobe != e_b)    begin bad_b++; if (at_b < 0) at_b = c; end
      if (sample_strobe != e_s) begin bad_s++; if (at_s < 0) at_s = c; end
      if (c < ncyc - 1) @(negedge clk);
    end
    check(req, $sformatf("os_tick mismatches (first at %0d)", at_t), bad_t, 0);
    check(req, $sformatf("bit_strobe mismatches (first at %0d)", at_b), bad_b, 0);
    check(req, $sformatf("sample_strobe mismatches (first at %0d)", at_s), bad_s, 0);
  endtask

  function automatic int win(input int code, input int dv);
    int r;
    r = (code < 3) ? 16 : code + 1;
    return 2 * r * dv + 4;
  endfunction

  function automatic logic [31:0] word(input int code, input int dv, input bit e);
    return (32'(code) << 24) | (32'(e) << 17) | 32'(dv);
  endfunction

  task automatic t_reset();
    @(negedge clk);
    check("R1", "reset readback", cfg_rd_data, 32'h0F00_0000);
    check("R1", "reset mode bits", {char10_mode, two_stop}, 0);
    watch(15, 0, 1'b0, 40, "R1 R8 reset idle");
  endtask

  task automatic t_ratio16();
    do_write(word(15, 3, 1'b0));
    watch(15, 3, 1'b0, win(15, 3), "R2 R3 R5 R6 ratio16");
  endtask

  task automatic t_low_forced();
    do_write(word(3, 4, 1'b0));
    watch(3, 4, 1'b0, win(3, 4), "R4 R7 ratio4 forced edge");
  endtask

  task automatic t_odd_ratio();
    do_write(word(4, 2, 1'b0));
    watch(4, 2, 1'b0, win(4, 2), "R4 R6 R7 ratio5");
  endtask

  task automatic t_illegal();
    do_write(word(1, 2, 1'b0));
    check("R9", "illegal code readback", cfg_rd_data, word(1, 2, 1'b0));
    watch(1, 2, 1'b0, win(1, 2), "R9 code1 acts as 16");
  endtask

  task automatic t_max_ratio();
    do_write(word(31, 1, 1'b1));
    watch(31, 1, 1'b1, win(31, 1), "R2 R7 ratio32 div1");
  endtask

  task automatic t_edge_bit();
    do_write(word(15, 4, 1'b1));
    watch(15, 4, 1'b1, win(15, 4), "R4 R7 edge bit at ratio16");
  endtask

  task automatic t_mask_modes();
    do_write(32'hFFFF_FFFF);
    check("R11", "all-ones readback", cfg_rd_data, 32'h3F02_3FFF);
    check("R10", "char10_mode set", char10_mode, 1);
    check("R10", "two_stop set", two_stop, 1);
    do_write(32'h0000_0000);
    check("R11", "zero readback", cfg_rd_data, 0);
    check("R10", "modes cleared", {char10_mode, two_stop}, 0);
    watch(0, 0, 1'b0, 40, "R8 divisor zero");
  endtask

  task automatic t_restart();
    do_write(word(7, 5, 1'b0));
    repeat (17) @(negedge clk);
    do_write(word(7, 5, 1'b0));
    watch(7, 5, 1'b0, win(7, 5), "R12 rewrite restarts phase");
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_ratio16();
    t_low_forced();
    t_odd_ratio();
    t_illegal();
    t_max_ratio();
    t_edge_bit();
    t_mask_modes();
    t_restart();
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    #200000;
    if (!done) begin
      done = 1'b1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

endmodule